// File: doc/BRIEF.md
# Set-Associative Write-Back Data Cache

This block is a byte-addressed data cache placed between a processor request port and a line-wide backing memory. It holds 1 KiB of data as 64 lines of 16 bytes, grouped into 16 sets of four ways. It works on a 16-bit byte address space. Reads that hit return their byte on the cycle after acceptance. Writes that hit change only the cached copy and mark the line dirty.

On a miss the cache picks a victim way in the indexed set. An empty way is always taken first. When the set is full, a free-running linear feedback shift register supplies the choice. A dirty victim is first written out to memory as one 128-bit beat. Then the wanted line is fetched as one 128-bit beat. A write miss allocates the line and merges its byte into the fetched data. The processor port stays not-ready from acceptance of a miss until its response cycle is over. Hit and miss counters let a test confirm the outcome of a known access sequence.

Top module: `cache_wb4`

## Requirements
- R1: A 16-bit address splits into tag = bits 15:8, set index = bits 7:4 and byte offset = bits 3:0. Each of the 16 sets holds 4 ways of 16-byte lines. Addresses with equal set index and different tags compete only for that set's ways.
- R2: Reset clears every valid and dirty bit and both counters. After reset req_ready is 1, rsp_valid is 0 and mem_req is 0, so the first access to any line after reset misses.
- R3: A read hit raises rsp_valid for exactly one cycle, on the cycle after acceptance, with the addressed byte on rsp_rdata. It increments hit_count by one.
- R4: A write hit stores its byte into the cached line only and marks the line dirty. It causes no memory traffic, and its response returns the written byte.
- R5: On a miss, miss_count increments and req_ready is 0 from the cycle after acceptance until the response cycle ends. The response cycle follows the fill acknowledge by one clock.
- R6: A write miss fetches the line from memory, merges the written byte at its offset, and leaves the line valid and dirty. The other bytes of the line read back with their memory values.
- R7: A victim that is valid and dirty is written back first, with mem_we=1, its own line address and the full line. Only then is the fill request (mem_we=0) issued. A clean victim is never written back.
- R8: If the indexed set has an invalid way, the victim is an invalid way. So four distinct tags in one set after reset are all resident at once.
- R9: In a full set the victim way is given by the low 2 bits of a free-running LFSR. The newly filled line hits on its next access, and evicted lines return correct data when fetched again.
- R10: mem_req stays high with a stable mem_addr and mem_we until mem_ack. mem_addr is always line aligned, with bits 3:0 equal to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Cache can accept a request |
| req_we | input | 1 | 1 = byte write, 0 = byte read |
| req_addr | input | 16 | Byte address |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_rdata | output | 8 | Read byte, or the written byte for writes |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 = write-back of a line, 0 = line fetch |
| mem_addr | output | 16 | Line-aligned memory address |
| mem_wdata | output | 128 | Line written back |
| mem_ack | input | 1 | Memory completes the current transfer |
| mem_rdata | input | 128 | Fetched line, valid with mem_ack |
| hit_count | output | 16 | Number of hits since reset |
| miss_count | output | 16 | Number of misses since reset |

## Verification
The bench builds the cache with its default parameters: 16-bit addresses, 16-byte lines, 4 ways, 16 sets and an 8-bit LFSR. A memory model acknowledges after three cycles. With four ways, five or more tags aimed at one set produce a full set and forced evictions in a few dozen accesses. Twelve write misses to one set then give an exact count of eight dirty write-backs, whichever ways the LFSR picks. Each written-back line is compared with the bench's own byte image. A clean-only set shows that no write-back happens for unmodified victims.

// File: rtl/cache_pkg.sv
package cache_pkg;
  localparam int CP_ADDR_W     = 16;
  localparam int CP_LINE_BYTES = 16;
  localparam int CP_WAYS       = 4;
  localparam int CP_SETS       = 16;
  localparam int CP_CNT_W      = 16;
  localparam int CP_LFSR_W     = 8;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WBACK = 2'd1,
    ST_FILL  = 2'd2,
    ST_RESP  = 2'd3
  } cstate_t;
endpackage

// File: rtl/cache_lfsr.sv
module cache_lfsr #(
  parameter int          LFSR_W = 8,
  parameter logic [7:0]  TAPS   = 8'hB8,
  parameter int          OUT_W  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [OUT_W-1:0] rnd
);
  logic [LFSR_W-1:0] q;

  // Galois form: shift right, fold taps in when the bit shifted out is 1
  always_ff @(posedge clk) begin
    if (!rst_n) q <= LFSR_W'(1);
    else        q <= (q >> 1) ^ (q[0] ? LFSR_W'(TAPS) : '0);
  end

  assign rnd = q[OUT_W-1:0];
endmodule

// File: rtl/cache_victim.sv
module cache_victim #(
  parameter int WAYS  = 4,
  parameter int WAY_W = 2
) (
  input  logic [WAYS-1:0]  valid,
  input  logic [WAY_W-1:0] rnd,
  output logic [WAY_W-1:0] way,
  output logic             has_free
);
  // the lowest-numbered empty way wins; only a full set uses the random pick
  always_comb begin
    way      = rnd;
    has_free = 1'b0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (!valid[i]) begin
        way      = WAY_W'(i);
        has_free = 1'b1;
      end
    end
  end
endmodule

// File: rtl/cache_tag_match.sv
module cache_tag_match #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 8,
  parameter int WAY_W = 2
) (
  input  logic [WAYS*TAG_W-1:0] tags,
  input  logic [WAYS-1:0]       valid,
  input  logic [TAG_W-1:0]      tag,
  output logic                  hit,
  output logic [WAY_W-1:0]      way
);
  logic [WAYS-1:0] eq;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign eq[w] = valid[w] && (tags[w*TAG_W +: TAG_W] == tag);
  end

  always_comb begin
    way = '0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (eq[i]) way = WAY_W'(i);
    end
  end

  assign hit = |eq;
endmodule

// File: rtl/cache_wb4.sv
module cache_wb4 import cache_pkg::*; #(
  parameter int ADDR_W     = CP_ADDR_W,
  parameter int LINE_BYTES = CP_LINE_BYTES,
  parameter int WAYS       = CP_WAYS,
  parameter int SETS       = CP_SETS,
  parameter int CNT_W      = CP_CNT_W,
  parameter int LFSR_W     = CP_LFSR_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic                     req_we,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [7:0]               req_wdata,
  output logic                     rsp_valid,
  output logic [7:0]               rsp_rdata,
  output logic                     mem_req,
  output logic                     mem_we,
  output logic [ADDR_W-1:0]        mem_addr,
  output logic [LINE_BYTES*8-1:0]  mem_wdata,
  input  logic                     mem_ack,
  input  logic [LINE_BYTES*8-1:0]  mem_rdata,
  output logic [CNT_W-1:0]         hit_count,
  output logic [CNT_W-1:0]         miss_count
);
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int IDX_W  = $clog2(SETS);
  localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;
  localparam int LINE_W = LINE_BYTES * 8;
  localparam int WAY_W  = $clog2(WAYS);

  // ---- address and line arithmetic ----
  function automatic logic [TAG_W-1:0] f_tag(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: TAG_W];
  endfunction
  function automatic logic [IDX_W-1:0] f_set(input logic [ADDR_W-1:0] a);
    return a[OFF_W +: IDX_W];
  endfunction
  function automatic logic [OFF_W-1:0] f_off(input logic [ADDR_W-1:0] a);
    return a[OFF_W-1:0];
  endfunction
  function automatic logic [7:0] f_get(input logic [LINE_W-1:0] l, input logic [OFF_W-1:0] o);
    return l[o*8 +: 8];
  endfunction
  function automatic logic [LINE_W-1:0] f_put(input logic [LINE_W-1:0] l,
                                              input logic [OFF_W-1:0] o, input logic [7:0] b);
    logic [LINE_W-1:0] r;
    r = l;
    r[o*8 +: 8] = b;
    return r;
  endfunction
  function automatic logic [ADDR_W-1:0] f_line(input logic [TAG_W-1:0] t, input logic [IDX_W-1:0] s);
    return {t, s, {OFF_W{1'b0}}};
  endfunction

  // ---- storage ----
  logic [TAG_W-1:0]  tag_q   [SETS][WAYS];
  logic [LINE_W-1:0] data_q  [SETS][WAYS];
  logic [WAYS-1:0]   valid_q [SETS];
  logic [WAYS-1:0]   dirty_q [SETS];

  cstate_t           state_q;
  logic [ADDR_W-1:0] addr_q;
  logic              we_q;
  logic [7:0]        wdata_q;
  logic [WAY_W-1:0]  vway_q;
  logic              rsp_valid_q;
  logic [7:0]        rsp_q;
  logic [CNT_W-1:0]  hit_q, miss_q;

  // ---- lookup ----
  logic [IDX_W-1:0]       sel_set, set_q;
  logic [WAYS*TAG_W-1:0]  set_tags;
  logic                   hit;
  logic [WAY_W-1:0]       hit_way;
  logic [WAY_W-1:0]       rnd_way, vic_way;
  logic                   set_free;

  assign set_q   = f_set(addr_q);
  assign sel_set = (state_q == ST_IDLE) ? f_set(req_addr) : set_q;

  always_comb begin
    for (int w = 0; w < WAYS; w++) set_tags[w*TAG_W +: TAG_W] = tag_q[sel_set][w];
  end

  cache_tag_match #(.WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)) u_match (
    .tags(set_tags), .valid(valid_q[sel_set]), .tag(f_tag(req_addr)),
    .hit(hit), .way(hit_way));

  cache_lfsr #(.LFSR_W(LFSR_W), .OUT_W(WAY_W)) u_lfsr (
    .clk(clk), .rst_n(rst_n), .rnd(rnd_way));

  cache_victim #(.WAYS(WAYS), .WAY_W(WAY_W)) u_victim (
    .valid(valid_q[sel_set]), .rnd(rnd_way), .way(vic_way), .has_free(set_free));

  // named events for the checker
  logic accept, hit_evt, miss_evt, vic_valid, vic_dirty, fill_done;
  assign accept    = req_valid && req_ready;
  assign hit_evt   = accept && hit;
  assign miss_evt  = accept && !hit;
  assign vic_valid = valid_q[sel_set][vic_way];
  assign vic_dirty = dirty_q[sel_set][vic_way];
  assign fill_done = (state_q == ST_FILL) && mem_ack;

  // ---- control, flags and counters ----
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      addr_q      <= '0;
      we_q        <= 1'b0;
      wdata_q     <= '0;
      vway_q      <= '0;
      rsp_valid_q <= 1'b0;
      rsp_q       <= '0;
      hit_q       <= '0;
      miss_q      <= '0;
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        dirty_q[s] <= '0;
      end
    end else begin
      rsp_valid_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          addr_q  <= req_addr;
          we_q    <= req_we;
          wdata_q <= req_wdata;
          if (hit) begin
            hit_q       <= hit_q + 1'b1;
            rsp_valid_q <= 1'b1;
            rsp_q       <= req_we ? req_wdata
                                  : f_get(data_q[sel_set][hit_way], f_off(req_addr));
            if (req_we) dirty_q[sel_set][hit_way] <= 1'b1;
          end else begin
            miss_q  <= miss_q + 1'b1;
            vway_q  <= vic_way;
            state_q <= (vic_valid && vic_dirty) ? ST_WBACK : ST_FILL;
          end
        end
        ST_WBACK: if (mem_ack) state_q <= ST_FILL;
        ST_FILL: if (mem_ack) begin
          valid_q[set_q][vway_q] <= 1'b1;
          dirty_q[set_q][vway_q] <= we_q;
          rsp_valid_q            <= 1'b1;
          rsp_q                  <= we_q ? wdata_q : f_get(mem_rdata, f_off(addr_q));
          state_q                <= ST_RESP;
        end
        ST_RESP: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // ---- tag and data arrays (no reset needed: guarded by valid) ----
  always_ff @(posedge clk) begin
    if (hit_evt && req_we)
      data_q[sel_set][hit_way] <= f_put(data_q[sel_set][hit_way], f_off(req_addr), req_wdata);
    if (fill_done) begin
      tag_q[set_q][vway_q]  <= f_tag(addr_q);
      data_q[set_q][vway_q] <= we_q ? f_put(mem_rdata, f_off(addr_q), wdata_q) : mem_rdata;
    end
  end

  // ---- outputs ----
  assign req_ready  = (state_q == ST_IDLE);
  assign rsp_valid  = rsp_valid_q;
  assign rsp_rdata  = rsp_q;
  assign mem_req    = (state_q == ST_WBACK) || (state_q == ST_FILL);
  assign mem_we     = (state_q == ST_WBACK);
  assign mem_addr   = (state_q == ST_WBACK) ? f_line(tag_q[set_q][vway_q], set_q)
                                            : f_line(f_tag(addr_q), set_q);
  assign mem_wdata  = data_q[set_q][vway_q];
  assign hit_count  = hit_q;
  assign miss_count = miss_q;
endmodule

// File: rtl/cache_wb4_chk.sv
module cache_wb4_chk #(
  parameter int ADDR_W = 16,
  parameter int OFF_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_ack,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              hit_evt,
  input logic              miss_evt,
  input logic              vic_valid,
  input logic              set_free
);
  a_r5_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !req_ready);

  a_r5_fill_then_respond: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we && mem_ack) |=> (rsp_valid && !req_ready));

  a_r3_hit_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    hit_evt |=> rsp_valid);

  a_r5_miss_goes_busy: assert property (@(posedge clk) disable iff (!rst_n)
    miss_evt |=> !req_ready);

  a_r7_writeback_before_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && mem_ack) |=> (mem_req && !mem_we));

  a_r10_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  a_r10_line_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[OFF_W-1:0] == '0));

  a_r8_empty_way_first: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_evt && set_free) |-> !vic_valid);
endmodule

bind cache_wb4 cache_wb4_chk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack), .mem_addr(mem_addr),
  .hit_evt(hit_evt), .miss_evt(miss_evt), .vic_valid(vic_valid), .set_free(set_free));

// File: tb/cache_wb4_test.sv
`timescale 1ns/1ps
module cache_wb4_test;
  localparam int LAT = 3;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0, req_we = 1'b0;
  logic [15:0]  req_addr = '0;
  logic [7:0]   req_wdata = '0;
  logic         req_ready, rsp_valid, mem_req, mem_we;
  logic [7:0]   rsp_rdata;
  logic [15:0]  mem_addr, hit_count, miss_count;
  logic [127:0] mem_wdata;
  logic         mem_ack = 1'b0;
  logic [127:0] mem_rdata = '0;

  int checks = 0, errors = 0, wb_count = 0, lat = 0;
  bit done = 0;

  cache_wb4 uut (.*);

  always #2 clk = ~clk;   // 250 MHz

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  // ---- reference byte image ----
  logic [127:0] bmem [int];
  logic [7:0]   gold [int];

  function automatic logic [7:0] init_byte(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction
  function automatic logic [7:0] gold_rd(input logic [15:0] a);
    if (gold.exists(int'(a))) return gold[int'(a)];
    return init_byte(a);
  endfunction
  function automatic logic [127:0] mem_line(input logic [11:0] idx);
    logic [127:0] l;
    if (bmem.exists(int'(idx))) return bmem[int'(idx)];
    for (int i = 0; i < 16; i++) l[i*8 +: 8] = init_byte({idx, 4'(i)});
    return l;
  endfunction

  // ---- memory model ----
  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ack <= 1'b0;
      lat = 0;
    end else if (mem_ack) begin
      mem_ack <= 1'b0;
      lat = 0;
    end else if (mem_req) begin
      if (lat == LAT) begin
        mem_ack <= 1'b1;
        chk("R10 line aligned address", 32'(mem_addr[3:0]), 32'h0);
        if (mem_we) begin
          wb_count++;
          for (int i = 0; i < 16; i++)
            chk("R7 written-back byte", 32'(mem_wdata[i*8 +: 8]),
                32'(gold_rd({mem_addr[15:4], 4'(i)})));
          bmem[int'(mem_addr[15:4])] = mem_wdata;
        end else begin
          mem_rdata <= mem_line(mem_addr[15:4]);
        end
      end else lat++;
    end
  end

  // ---- scoreboard ----
  logic [7:0] exp_q [$];
  string      rq_q  [$];

  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) chk("R3 unexpected response", 32'(rsp_rdata), 32'hFFFF_FFFF);
      else begin
        string r;
        logic [7:0] e;
        r = rq_q.pop_front();
        e = exp_q.pop_front();
        chk(r, 32'(rsp_rdata), 32'(e));
      end
    end
  end

  function automatic logic [15:0] mk(input logic [7:0] t, input logic [3:0] s, input logic [3:0] o);
    return {t, s, o};
  endfunction

  // exp_hit: 1 hit expected, 0 miss expected, -1 either
  task automatic access(input logic we, input logic [15:0] a, input logic [7:0] d,
                        input int exp_hit, input string r);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d;
    if (we) begin gold[int'(a)] = d; exp_q.push_back(d); end
    else exp_q.push_back(gold_rd(a));
    rq_q.push_back(r);
    @(negedge clk);
    req_valid = 1'b0;
    if (exp_hit == 1)      chk({r, " hit response next cycle"}, 32'(rsp_valid), 32'h1);
    else if (exp_hit == 0) chk({r, " miss holds port not-ready"}, 32'(req_ready), 32'h0);
  endtask

  task automatic drain();
    @(negedge clk);
    while (exp_q.size() != 0 || !req_ready) @(negedge clk);
    @(negedge clk);
  endtask

  int h0, m0, w0;
  task automatic snap();
    h0 = int'(hit_count); m0 = int'(miss_count); w0 = wb_count;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R2: state after reset
    chk("R2 req_ready after reset", 32'(req_ready), 32'h1);
    chk("R2 rsp_valid after reset", 32'(rsp_valid), 32'h0);
    chk("R2 mem_req after reset",   32'(mem_req),   32'h0);
    chk("R2 counters after reset",  32'({hit_count, miss_count}), 32'h0);

    // R1/R8: four tags in set 2 all fit; re-reads hit
    snap();
    for (int t = 1; t <= 4; t++) access(1'b0, mk(8'(t), 4'h2, 4'h0), 8'h0, 0, "R8 fill empty way");
    for (int t = 1; t <= 4; t++) access(1'b0, mk(8'(t), 4'h2, 4'(t)), 8'h0, 1, "R8 resident after fill");
    drain();
    chk("R8 misses in set 2", 32'(int'(miss_count) - m0), 32'd4);
    chk("R3 hits in set 2",   32'(int'(hit_count) - h0), 32'd4);
    // R1: same tags in set 3 do not disturb set 2
    access(1'b0, mk(8'h1, 4'h3, 4'h0), 8'h0, 0, "R1 other set misses");
    access(1'b0, mk(8'h1, 4'h2, 4'hF), 8'h0, 1, "R1 set 2 untouched");

    // R4: write hit, no memory traffic
    drain(); snap();
    access(1'b1, mk(8'h1, 4'h2, 4'h5), 8'hA5, 1, "R4 write hit");
    access(1'b0, mk(8'h1, 4'h2, 4'h5), 8'h0, 1, "R4 read back written byte");
    drain();
    chk("R4 no write-back on write hit", 32'(wb_count - w0), 32'd0);

    // R7/R9: clean victims in set 9
    snap();
    for (int t = 1; t <= 6; t++) access(1'b0, mk(8'(t), 4'h9, 4'h3), 8'h0, 0, "R9 read miss in full set");
    access(1'b0, mk(8'h6, 4'h9, 4'h4), 8'h0, 1, "R9 new line resident");
    drain();
    chk("R7 clean victims never written back", 32'(wb_count - w0), 32'd0);
    chk("R5 miss counter set 9", 32'(int'(miss_count) - m0), 32'd6);

    // R6: write-allocate
    access(1'b1, mk(8'h33, 4'hC, 4'h7), 8'h3C, 0, "R6 write miss");
    access(1'b0, mk(8'h33, 4'hC, 4'h7), 8'h0, 1, "R6 merged byte");
    access(1'b0, mk(8'h33, 4'hC, 4'h8), 8'h0, 1, "R6 neighbour byte from memory");

    // R7: dirty victims in set 4
    drain(); snap();
    for (int t = 0; t < 12; t++)
      access(1'b1, mk(8'h40 + 8'(t), 4'h4, 4'h3), 8'hC3 ^ 8'(t), 0, "R7 write miss");
    drain();
    chk("R7 dirty evictions written back", 32'(wb_count - w0), 32'd8);
    for (int t = 0; t < 12; t++)
      access(1'b0, mk(8'h40 + 8'(t), 4'h4, 4'h3), 8'h0, -1, "R9 evicted data correct");
    drain();

    // R2: a reset empties the cache
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R2 counters cleared", 32'({hit_count, miss_count}), 32'h0);
    access(1'b0, mk(8'h6, 4'h9, 4'h4), 8'h0, 0, "R2 first access after reset");
    access(1'b0, mk(8'h6, 4'h9, 4'h4), 8'h0, 1, "R3 second access hits");
    drain();
    chk("R5 miss count after reset", 32'(miss_count), 32'd1);
    chk("R3 hit count after reset",  32'(hit_count),  32'd1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule